// File: doc/BRIEF.md
# Multi-Context Shared Translation Buffer

This block is a small fully associative translation buffer that four hardware thread contexts use together. Each context owns a private address space number (ASN) register. A lookup takes the requesting context's ASN and appends it to the virtual page number, then compares the result with every entry. As a result, contexts that run in different address spaces never hit each other's translations, and contexts that share an ASN share their translations.

Software switches a context to another address space by writing that context's ASN register, and no entry is flushed when it does. Stale translations are removed only by the two explicit invalidate commands. One clears every entry tagged with a chosen ASN and the other clears the whole buffer. New translations come in through a fill port. A fill is tagged with the ASN of the context named on that port. It goes into a slot chosen by a fixed priority: first a slot that already holds the same translation, then a free slot, then a rotating victim.

Top module: `shared_xlate_buf`

## Requirements
- R1: After synchronous reset every entry is invalid, every context's ASN register holds 0, and every lookup misses.
- R2: A lookup is combinational. `lk_hit` is 1 in the same cycle exactly when a valid entry holds both the requesting context's ASN and `lk_vpn`, and `lk_ppn` then shows that entry's physical page number.
- R3: Each of the four contexts has its own 8-bit ASN register, written through `asn_we`/`asn_tid`/`asn_wdata` and taking effect at the next clock edge. Lookups and fills in the write cycle use the value held before that edge.
- R4: Writing an ASN register leaves every entry valid and unchanged. A context that gets its earlier ASN written back hits its earlier translations again.
- R5: A fill is tagged with the ASN of `fill_tid` and becomes visible at the next clock edge. A lookup in the fill cycle sees the contents from before the fill, even when it addresses the slot being filled.
- R6: Fill slot choice, in priority order: a valid entry whose ASN and VPN both equal the fill's (its PPN is replaced, so no translation is ever held twice); otherwise the lowest-numbered invalid entry; otherwise the rotating pointer. The pointer starts at entry 0 after reset and moves on by one, wrapping, each time it is used.
- R7: `inv_asn_en` clears every entry whose ASN equals `inv_asn_val` and leaves all other entries valid.
- R8: `inv_all` clears every entry.
- R9: When an invalidate and a fill fall in the same cycle, the slot is chosen from the contents before the invalidation, the invalidation is applied, and the filled entry stays valid.
- R10: On a miss `lk_ppn` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_tid | input | 2 | Context issuing the lookup |
| lk_vpn | input | 20 | Virtual page number to translate |
| lk_hit | output | 1 | Lookup matched a valid entry |
| lk_ppn | output | 20 | Translated physical page number, 0 on miss |
| fill_en | input | 1 | Write a new translation |
| fill_tid | input | 2 | Context whose ASN tags the fill |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_ppn | input | 20 | Physical page number of the fill |
| asn_we | input | 1 | Write a context's ASN register |
| asn_tid | input | 2 | Context whose ASN is written |
| asn_wdata | input | 8 | New ASN value |
| inv_all | input | 1 | Clear every entry |
| inv_asn_en | input | 1 | Clear entries tagged with `inv_asn_val` |
| inv_asn_val | input | 8 | ASN selected for invalidation |

## Verification
The two functions that can meet in one cycle are a lookup and a fill aimed at the same translation. The bench provokes this by driving a fill and a lookup of that same ASN and VPN between the same two edges, once into a free slot and once over an existing entry. Before the edge the lookup must show the old state, a miss in the first case and the old PPN in the second. After the edge it must show the new translation. The same pattern is repeated with an ASN write, and with an invalidate that lands on the fill cycle. All results are compared against a behavioural model built from the requirements.

// File: rtl/xlt_pkg.sv
package xlt_pkg;
  localparam int XLT_ENTRIES = 16;
  localparam int XLT_THREADS = 4;
  localparam int XLT_ASN_W   = 8;
  localparam int XLT_VPN_W   = 20;
  localparam int XLT_PPN_W   = 20;

  typedef enum logic [1:0] {
    VS_HIT  = 2'd0,
    VS_FREE = 2'd1,
    VS_RR   = 2'd2
  } victim_src_e;
endpackage

// File: rtl/xlt_asn_bank.sv
module xlt_asn_bank #(
  parameter int THREADS = 4,
  parameter int ASN_W   = 8,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [TID_W-1:0] wtid,
  input  logic [ASN_W-1:0] wdata,
  input  logic [TID_W-1:0] rd_a_tid,
  output logic [ASN_W-1:0] rd_a_asn,
  input  logic [TID_W-1:0] rd_b_tid,
  output logic [ASN_W-1:0] rd_b_asn
);
  logic [ASN_W-1:0] asn_q [THREADS];

  for (genvar t = 0; t < THREADS; t++) begin : g_ctx
    always_ff @(posedge clk) begin
      if (rst)
        asn_q[t] <= '0;
      else if (we && wtid == TID_W'(t))
        asn_q[t] <= wdata;
    end
  end

  assign rd_a_asn = asn_q[rd_a_tid];
  assign rd_b_asn = asn_q[rd_b_tid];

  AST_ASN_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    we |=> asn_q[$past(wtid)] == $past(wdata)); // R3
endmodule

// File: rtl/xlt_cam_match.sv
module xlt_cam_match #(
  parameter int ENTRIES = 16,
  parameter int ASN_W   = 8,
  parameter int VPN_W   = 20
) (
  input  logic [ENTRIES-1:0] valid,
  input  logic [ASN_W-1:0]   ent_asn [ENTRIES],
  input  logic [VPN_W-1:0]   ent_vpn [ENTRIES],
  input  logic [ASN_W-1:0]   key_asn,
  input  logic [VPN_W-1:0]   key_vpn,
  output logic [ENTRIES-1:0] match
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match[e] = valid[e] && (ent_asn[e] == key_asn) && (ent_vpn[e] == key_vpn);
  end
endmodule

// File: rtl/xlt_victim_sel.sv
module xlt_victim_sel
  import xlt_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] same_match,
  input  logic               commit,
  output logic [IDX_W-1:0]   vic_idx,
  output victim_src_e        vic_src
);
  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] hit_idx, free_idx;
  logic             any_hit, any_free;

  always_comb begin
    hit_idx  = '0;
    any_hit  = 1'b0;
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (same_match[i]) begin
        hit_idx = IDX_W'(i);
        any_hit = 1'b1;
      end
      if (!valid[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_hit) begin
      vic_idx = hit_idx;
      vic_src = VS_HIT;
    end else if (any_free) begin
      vic_idx = free_idx;
      vic_src = VS_FREE;
    end else begin
      vic_idx = rr_q;
      vic_src = VS_RR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rr_q <= '0;
    else if (commit && vic_src == VS_RR)
      rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  end

  AST_VIC_FREE_IS_FREE: assert property (@(posedge clk) disable iff (rst)
    (vic_src == VS_FREE) |-> !valid[vic_idx]); // R6
  AST_VIC_RR_FULL: assert property (@(posedge clk) disable iff (rst)
    (vic_src == VS_RR) |-> (&valid)); // R6
endmodule

// File: rtl/shared_xlate_buf.sv
module shared_xlate_buf
  import xlt_pkg::*;
#(
  parameter int ENTRIES = XLT_ENTRIES,
  parameter int THREADS = XLT_THREADS,
  parameter int ASN_W   = XLT_ASN_W,
  parameter int VPN_W   = XLT_VPN_W,
  parameter int PPN_W   = XLT_PPN_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TID_W-1:0] lk_tid,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             fill_en,
  input  logic [TID_W-1:0] fill_tid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             asn_we,
  input  logic [TID_W-1:0] asn_tid,
  input  logic [ASN_W-1:0] asn_wdata,
  input  logic             inv_all,
  input  logic             inv_asn_en,
  input  logic [ASN_W-1:0] inv_asn_val
);
  logic [ENTRIES-1:0] valid_q;
  logic [ASN_W-1:0]   ent_asn [ENTRIES];
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [PPN_W-1:0]   ent_ppn [ENTRIES];

  logic [ASN_W-1:0]   lk_asn, fl_asn;
  logic [ENTRIES-1:0] lk_match, fl_match, inv_mask;
  logic [IDX_W-1:0]   vic_idx;
  victim_src_e        vic_src;

  xlt_asn_bank #(.THREADS(THREADS), .ASN_W(ASN_W)) u_asn (
    .clk      (clk),
    .rst      (rst),
    .we       (asn_we),
    .wtid     (asn_tid),
    .wdata    (asn_wdata),
    .rd_a_tid (lk_tid),
    .rd_a_asn (lk_asn),
    .rd_b_tid (fill_tid),
    .rd_b_asn (fl_asn)
  );

  xlt_cam_match #(.ENTRIES(ENTRIES), .ASN_W(ASN_W), .VPN_W(VPN_W)) u_lk_cam (
    .valid   (valid_q),
    .ent_asn (ent_asn),
    .ent_vpn (ent_vpn),
    .key_asn (lk_asn),
    .key_vpn (lk_vpn),
    .match   (lk_match)
  );

  xlt_cam_match #(.ENTRIES(ENTRIES), .ASN_W(ASN_W), .VPN_W(VPN_W)) u_fl_cam (
    .valid   (valid_q),
    .ent_asn (ent_asn),
    .ent_vpn (ent_vpn),
    .key_asn (fl_asn),
    .key_vpn (fill_vpn),
    .match   (fl_match)
  );

  xlt_victim_sel #(.ENTRIES(ENTRIES)) u_vic (
    .clk        (clk),
    .rst        (rst),
    .valid      (valid_q),
    .same_match (fl_match),
    .commit     (fill_en),
    .vic_idx    (vic_idx),
    .vic_src    (vic_src)
  );

  // Read side: hit vector is one-hot at most, so an OR of masked PPNs selects.
  always_comb begin
    lk_hit = |lk_match;
    lk_ppn = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (lk_match[e]) lk_ppn = lk_ppn | ent_ppn[e];
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_inv
    assign inv_mask[e] = inv_all || (inv_asn_en && ent_asn[e] == inv_asn_val);
  end

  // Valid bits: invalidation first, then the fill slot is set.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      for (int e = 0; e < ENTRIES; e++)
        if (inv_mask[e]) valid_q[e] <= 1'b0;
      if (fill_en) valid_q[vic_idx] <= 1'b1;
    end
  end

  // Payload arrays: single write port, no reset.
  always_ff @(posedge clk) begin
    if (fill_en) begin
      ent_asn[vic_idx] <= fl_asn;
      ent_vpn[vic_idx] <= fill_vpn;
      ent_ppn[vic_idx] <= fill_ppn;
    end
  end

  AST_LK_ONE_MATCH: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match)); // R6
  AST_MISS_PPN_ZERO: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> lk_ppn == '0); // R10
  AST_ASN_NO_FLUSH: assert property (@(posedge clk) disable iff (rst)
    (asn_we && !fill_en && !inv_all && !inv_asn_en) |=> $stable(valid_q)); // R4
  AST_INV_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (inv_all && !fill_en) |=> valid_q == '0); // R8
  AST_FILL_SURVIVES: assert property (@(posedge clk) disable iff (rst)
    fill_en |=> valid_q[$past(vic_idx)]); // R9
endmodule

// File: tb/shared_xlate_buf_test.sv
`timescale 1ns/1ps
module shared_xlate_buf_test;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  lk_tid = '0;
  logic [19:0] lk_vpn = '0;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic        fill_en = 1'b0;
  logic [1:0]  fill_tid = '0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_ppn = '0;
  logic        asn_we = 1'b0;
  logic [1:0]  asn_tid = '0;
  logic [7:0]  asn_wdata = '0;
  logic        inv_all = 1'b0;
  logic        inv_asn_en = 1'b0;
  logic [7:0]  inv_asn_val = '0;

  int checks = 0;
  int errors = 0;

  // Reference model built from the requirements
  bit          mv   [N];
  logic [7:0]  masn [N];
  logic [19:0] mvpn [N];
  logic [19:0] mppn [N];
  logic [7:0]  mtasn [4];
  int          mrr;

  always #2 clk = ~clk;

  shared_xlate_buf uut (
    .clk(clk), .rst(rst), .lk_tid(lk_tid), .lk_vpn(lk_vpn), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .fill_en(fill_en), .fill_tid(fill_tid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .asn_we(asn_we), .asn_tid(asn_tid), .asn_wdata(asn_wdata),
    .inv_all(inv_all), .inv_asn_en(inv_asn_en), .inv_asn_val(inv_asn_val)
  );

  task automatic model_reset();
    for (int e = 0; e < N; e++) mv[e] = 1'b0;
    for (int t = 0; t < 4; t++) mtasn[t] = 8'h00;
    mrr = 0;
  endtask

  task automatic chk(input logic [1:0] tid, input logic [19:0] vpn, input string req);
    bit exp_hit;
    logic [19:0] exp_ppn;
    exp_hit = 1'b0;
    exp_ppn = '0;
    for (int e = 0; e < N; e++)
      if (mv[e] && masn[e] == mtasn[tid] && mvpn[e] == vpn) begin
        exp_hit = 1'b1;
        exp_ppn = mppn[e];
      end
    lk_tid = tid;
    lk_vpn = vpn;
    #0.2;
    checks++;
    if (lk_hit !== exp_hit || lk_ppn !== exp_ppn) begin
      errors++;
      $display("FAIL %s tid=%0d vpn=%h: hit=%b ppn=%h expected hit=%b ppn=%h",
               req, tid, vpn, lk_hit, lk_ppn, exp_hit, exp_ppn);
    end
  endtask

  // One clock with any mix of commands; optional lookup checked before the edge.
  task automatic step(input bit f, input logic [1:0] ft, input logic [19:0] fv, input logic [19:0] fp,
                      input bit aw, input logic [1:0] at, input logic [7:0] ad,
                      input bit ia, input bit ie, input logic [7:0] iv,
                      input bit pre, input logic [1:0] pt, input logic [19:0] pv, input string req);
    int vic;
    logic [7:0] fasn;
    @(negedge clk);
    fill_en = f; fill_tid = ft; fill_vpn = fv; fill_ppn = fp;
    asn_we = aw; asn_tid = at; asn_wdata = ad;
    inv_all = ia; inv_asn_en = ie; inv_asn_val = iv;
    if (pre) chk(pt, pv, req);
    @(posedge clk);
    #0.2;
    fill_en = 1'b0; asn_we = 1'b0; inv_all = 1'b0; inv_asn_en = 1'b0;
    fasn = mtasn[ft];
    vic = -1;
    for (int e = 0; e < N; e++)
      if (vic < 0 && mv[e] && masn[e] == fasn && mvpn[e] == fv) vic = e;
    for (int e = 0; e < N; e++)
      if (vic < 0 && !mv[e]) vic = e;
    if (f && vic < 0) begin
      vic = mrr;
      mrr = (mrr + 1) % N;
    end
    for (int e = 0; e < N; e++)
      if (ia || (ie && masn[e] == iv)) mv[e] = 1'b0;
    if (f) begin
      mv[vic] = 1'b1; masn[vic] = fasn; mvpn[vic] = fv; mppn[vic] = fp;
    end
    if (aw) mtasn[at] = ad;
  endtask

  task automatic fill(input logic [1:0] t, input logic [19:0] v, input logic [19:0] p);
    step(1, t, v, p, 0, 0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic set_asn(input logic [1:0] t, input logic [7:0] a);
    step(0, 0, 0, 0, 1, t, a, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic sweep(input string req);
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < 4; i++) chk(2'(t), 20'h00100 + 20'(i), req);
      for (int i = 0; i < 8; i++) chk(2'(t), 20'h00200 + 20'(i), req);
      for (int i = 0; i < 2; i++) chk(2'(t), 20'h00300 + 20'(i), req);
      chk(2'(t), 20'h00400, req);
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #0.2 rst = 1'b0;

    sweep("R1");  // empty after reset, misses give 0 (R10)
    fill(2'd0, 20'h00100, 20'hA0000);
    chk(2'd2, 20'h00100, "R1"); // all ASNs are 0, so any context hits
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "");

    set_asn(2'd0, 8'h11); set_asn(2'd1, 8'h22);
    set_asn(2'd2, 8'h33); set_asn(2'd3, 8'h11);
    for (int t = 0; t < 4; t++)
      for (int i = 0; i < 4; i++)
        fill(2'(t), 20'h00100 + 20'(i), 20'hA0000 + 20'(t * 16 + i));
    sweep("R2"); // context 3 overwrote context 0's slots (R6, R3)

    for (int i = 0; i < 8; i++) fill(2'd1, 20'h00200 + 20'(i), 20'hB0000 + 20'(i));
    sweep("R6"); // four free slots then rotating entries 0..3

    step(1, 2'd2, 20'h00300, 20'hC0000, 0, 0, 0, 0, 0, 0, 1, 2'd2, 20'h00300, "R5");
    chk(2'd2, 20'h00300, "R5");
    step(1, 2'd1, 20'h00204, 20'hC1111, 0, 0, 0, 0, 0, 0, 1, 2'd1, 20'h00204, "R5");
    chk(2'd1, 20'h00204, "R5");

    step(1, 2'd2, 20'h00301, 20'hC2222, 1, 2'd2, 8'h55, 0, 0, 0, 1, 2'd2, 20'h00301, "R3");
    chk(2'd2, 20'h00301, "R3");
    set_asn(2'd2, 8'h33);
    chk(2'd2, 20'h00301, "R3");

    set_asn(2'd1, 8'h44);
    sweep("R4");
    set_asn(2'd1, 8'h22);
    sweep("R4");

    step(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h22, 0, 0, 0, "");
    sweep("R7");

    for (int i = 0; i < 4; i++) fill(2'd1, 20'h00200 + 20'(i), 20'hD0000 + 20'(i));
    step(1, 2'd0, 20'h00400, 20'hE0000, 0, 0, 0, 1, 0, 0, 1, 2'd0, 20'h00400, "R9");
    sweep("R9");

    step(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "");
    sweep("R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule